// File: doc/BRIEF.md
# Repeated Check Event Filter

This block sits in front of the software handlers that check memory accesses against per-location metadata. Each incoming check event carries an address and an access kind (load or store). A check whose address and kind are both unchanged, and whose metadata cannot have changed since it was last delivered, would give the same result again. The block drops such repeats and passes every other event through to the handlers.

A small set-associative table holds the checks delivered since the last clear. Each entry is tagged by the address together with the access kind, so loads and stores are remembered separately. When software sees an event that may change metadata, it pulses the flush input and the table empties in one cycle. Examples are a free, which ends the allocation check of an address, or a lock or unlock, which starts a new interval in race detection. In race detection this means only the first load and the first store to each location between two synchronization points reach the handlers. A disable input makes the block transparent.

Passed events appear on registered outputs one cycle after they are presented.

Top module: `ief_filter`

## Requirements
- R1: Synchronous reset makes `out_valid` low and invalidates every entry, so the first event after reset passes.
- R2: An event that misses in the table is passed: one cycle later `out_valid` is high and `out_addr`/`out_store` equal the event's address and kind. No output appears without an input event.
- R3: With the filter enabled and no flush, an event whose address and kind match an entry installed since the last flush is dropped, and `out_valid` stays low in the following cycle.
- R4: Loads (`ev_store`=0) and stores (`ev_store`=1) have separate entries. A load to an address does not filter a later store to it, and a store does not filter a later load.
- R5: A flush clears all entries in a single cycle. Any event after that cycle misses until it is installed again.
- R6: An event presented in the same cycle as a flush is passed, even if it would hit, and it is not installed.
- R7: With `en` low every event passes and nothing is installed. Entries present before the disable are kept and filter again once `en` returns high.
- R8: The set is chosen by the low log2(SETS) address bits. Events in different sets never evict each other, and up to WAYS distinct address/kind pairs per set are all retained.
- R9: A miss fills the lowest-numbered invalid way. In a full set the victim is chosen by tree pseudo-LRU, updated on every hit and fill. Filling a set in order with tags A,B,C,D and then E evicts A. Refilling A then evicts C, while B and D stay resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Filtering enable; low passes every event |
| flush | input | 1 | Clear all entries (metadata may have changed) |
| ev_valid | input | 1 | Check event present this cycle |
| ev_addr | input | ADDR_W | Address of the checked access |
| ev_store | input | 1 | Access kind: 0 load, 1 store |
| out_valid | output | 1 | Event delivered to the handlers |
| out_addr | output | ADDR_W | Address of the delivered event |
| out_store | output | 1 | Access kind of the delivered event |

## Verification
The bench builds the filter with ADDR_W=6, SETS=4 and WAYS=4. With these values a sweep over addresses 0 to 7 in both access kinds fills every way of every set without eviction. Each expected pass or drop can therefore be computed from a simple seen-since-flush record. The same small geometry puts five colliding tags within reach of one set with a handful of events, so the pseudo-LRU victim order can be checked step by step.

// File: rtl/ief_pkg.sv
package ief_pkg;
  // Access kinds carried with each check event
  typedef enum logic {
    KIND_LOAD  = 1'b0,
    KIND_STORE = 1'b1
  } access_kind_e;
endpackage

// File: rtl/ief_lookup.sv
module ief_lookup #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]            row_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] row_tags,
  input  logic [TAG_W-1:0]           probe,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = row_valid[w] && (row_tags[w] == probe);
  end

  always_comb begin
    hit     = |match;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/ief_free_pick.sv
module ief_free_pick #(
  parameter int WAYS = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]  row_valid,
  output logic             any_free,
  output logic [WAY_W-1:0] free_way
);
  always_comb begin
    any_free = ~&row_valid;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!row_valid[w]) free_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/ief_plru.sv
module ief_plru #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic [NODES-1:0] tree,
  input  logic [WAY_W-1:0] acc_way,
  output logic [WAY_W-1:0] victim,
  output logic [NODES-1:0] tree_next
);
  // Heap-ordered tree: node n (1-based) has children 2n and 2n+1.
  // A node bit of 0 steers the victim search left.
  always_comb begin
    int node;
    node = 1;
    for (int l = 0; l < WAY_W; l++) begin
      node = 2 * node + int'(tree[node-1]);
    end
    victim = WAY_W'(node - WAYS);
  end

  always_comb begin
    int node;
    tree_next = tree;
    node = 1;
    for (int l = 0; l < WAY_W; l++) begin
      tree_next[node-1] = ~acc_way[WAY_W-1-l];
      node = 2 * node + int'(acc_way[WAY_W-1-l]);
    end
  end
endmodule

// File: rtl/ief_filter.sv
module ief_filter #(
  parameter int ADDR_W = 16,
  parameter int SETS   = 16,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              flush,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              ev_store,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_store
);
  import ief_pkg::*;

  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - SET_W + 1;
  localparam int NODES = WAYS - 1;

  logic [SETS-1:0][WAYS-1:0]  valid_q;
  logic [SETS-1:0][NODES-1:0] plru_q;

  logic [SET_W-1:0]           set_idx;
  logic [TAG_W-1:0]           ev_tag;
  logic [WAYS-1:0][TAG_W-1:0] row_tags;
  logic                       hit, any_free;
  logic [WAY_W-1:0]           hit_way, free_way, victim, fill_way, acc_way;
  logic [NODES-1:0]           plru_nxt;
  logic                       active, install, drop;
  access_kind_e               kind;

  assign kind    = access_kind_e'(ev_store);
  assign set_idx = ev_addr[SET_W-1:0];
  assign ev_tag  = {ev_addr[ADDR_W-1:SET_W], kind == KIND_STORE};

  // One tag memory per way: written on fill, read at the event's set
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] mem [SETS];
    always_ff @(posedge clk) begin
      if (install && fill_way == WAY_W'(w)) mem[set_idx] <= ev_tag;
    end
    assign row_tags[w] = mem[set_idx];
  end

  ief_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
    .row_valid (valid_q[set_idx]),
    .row_tags  (row_tags),
    .probe     (ev_tag),
    .hit       (hit),
    .hit_way   (hit_way)
  );

  ief_free_pick #(.WAYS(WAYS)) u_free (
    .row_valid (valid_q[set_idx]),
    .any_free  (any_free),
    .free_way  (free_way)
  );

  ief_plru #(.WAYS(WAYS)) u_plru (
    .tree      (plru_q[set_idx]),
    .acc_way   (acc_way),
    .victim    (victim),
    .tree_next (plru_nxt)
  );

  assign active   = ev_valid && en && !flush;
  assign drop     = active && hit;
  assign install  = active && !hit;
  assign fill_way = any_free ? free_way : victim;
  assign acc_way  = hit ? hit_way : fill_way;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= '0;
      plru_q    <= '0;
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_store <= 1'b0;
    end else begin
      if (flush) begin
        valid_q <= '0;
      end else if (install) begin
        valid_q[set_idx][fill_way] <= 1'b1;
      end
      if (active) plru_q[set_idx] <= plru_nxt;
      out_valid <= ev_valid && !drop;
      out_addr  <= ev_addr;
      out_store <= ev_store;
    end
  end
endmodule

// File: rtl/ief_filter_chk.sv
module ief_filter_chk #(
  parameter int ADDR_W = 16,
  parameter int SETS   = 16,
  parameter int WAYS   = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 en,
  input logic                 flush,
  input logic                 ev_valid,
  input logic [ADDR_W-1:0]    ev_addr,
  input logic                 ev_store,
  input logic                 out_valid,
  input logic [ADDR_W-1:0]    out_addr,
  input logic                 out_store,
  input logic [SETS*WAYS-1:0] valid_q
);
  // R1: the cycle after reset shows no delivered event
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);

  // R2: a delivered event always comes from an input event, unchanged
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(ev_valid));
  p_pass_fields_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_addr == $past(ev_addr) && out_store == $past(ev_store)));

  // R5: flush empties the whole table in one cycle
  p_flush_clears_r5: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_q == '0));
  p_after_flush_miss_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(flush) && ev_valid) |=> out_valid);

  // R6: an event alongside a flush is delivered
  p_flush_event_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && flush) |=> out_valid);

  // R7: disabled filter delivers everything and installs nothing
  p_disabled_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !en) |=> out_valid);
  p_disabled_no_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (!en && !flush) |=> $stable(valid_q));
endmodule

bind ief_filter ief_filter_chk #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .flush     (flush),
  .ev_valid  (ev_valid),
  .ev_addr   (ev_addr),
  .ev_store  (ev_store),
  .out_valid (out_valid),
  .out_addr  (out_addr),
  .out_store (out_store),
  .valid_q   (valid_q)
);

// File: tb/ief_filter_test.sv
`timescale 1ns/1ps
module ief_filter_test;
  localparam int ADDR_W = 6;
  localparam int SETS   = 4;
  localparam int WAYS   = 4;

  logic clk = 1'b0;
  logic rst, en, flush, ev_valid, ev_store;
  logic [ADDR_W-1:0] ev_addr;
  logic out_valid, out_store;
  logic [ADDR_W-1:0] out_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ief_filter #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) uut (
    .clk(clk), .rst(rst), .en(en), .flush(flush), .ev_valid(ev_valid),
    .ev_addr(ev_addr), .ev_store(ev_store), .out_valid(out_valid),
    .out_addr(out_addr), .out_store(out_store)
  );

  // Present one event (optionally with flush) and check the delivery a cycle later
  task automatic send(input int a, input bit st, input bit fl, input bit exp_pass,
                      input string req);
    @(negedge clk);
    ev_valid = 1'b1; ev_addr = ADDR_W'(a); ev_store = st; flush = fl;
    @(posedge clk);
    #1;
    ev_valid = 1'b0; flush = 1'b0;
    checks++;
    if (out_valid !== exp_pass ||
        (exp_pass && (out_addr !== ADDR_W'(a) || out_store !== st))) begin
      failures++;
      $display("FAIL %s: got v=%0b a=%0d s=%0b exp v=%0b a=%0d s=%0b",
               req, out_valid, out_addr, out_store, exp_pass, a, st);
    end
  endtask

  task automatic idle_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; en = 1'b1; flush = 1'b0; ev_valid = 1'b0; ev_addr = '0; ev_store = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1: got v=%0b exp v=0", out_valid);
    end

    // R1/R2/R4/R8: first touch of each address/kind passes; 4 pairs per set fit
    for (int k = 0; k < 2; k++)
      for (int a = 0; a < 8; a++) send(a, k[0], 1'b0, 1'b1, "R2/R4/R8 first");
    // R3: every repeat is dropped
    for (int k = 0; k < 2; k++)
      for (int a = 0; a < 8; a++) send(a, k[0], 1'b0, 1'b0, "R3/R8 repeat");

    // R5: after flush everything misses again
    idle_flush();
    for (int a = 0; a < 8; a++) send(a, 1'b0, 1'b0, 1'b1, "R5 after flush");
    // R4: stores still miss though loads are cached
    send(3, 1'b1, 1'b0, 1'b1, "R4 store after load");
    send(3, 1'b1, 1'b0, 1'b0, "R3 store repeat");

    // R7: disabled passes everything and installs nothing; contents kept
    en = 1'b0;
    send(0, 1'b0, 1'b0, 1'b1, "R7 disabled cached");
    send(8, 1'b0, 1'b0, 1'b1, "R7 disabled new");
    en = 1'b1;
    send(0, 1'b0, 1'b0, 1'b0, "R7 retained");
    send(8, 1'b0, 1'b0, 1'b1, "R7 not installed");
    send(8, 1'b0, 1'b0, 1'b0, "R3 installed now");

    // R6: event concurrent with flush passes and is not installed
    send(4, 1'b0, 1'b1, 1'b1, "R6 with flush");
    send(4, 1'b0, 1'b0, 1'b1, "R6 not installed");
    send(4, 1'b0, 1'b0, 1'b0, "R3 after R6");

    // R9: five colliding loads in set 1 (A=1,B=5,C=9,D=13,E=17)
    idle_flush();
    send(1,  1'b0, 1'b0, 1'b1, "R9 fill A");
    send(5,  1'b0, 1'b0, 1'b1, "R9 fill B");
    send(9,  1'b0, 1'b0, 1'b1, "R9 fill C");
    send(13, 1'b0, 1'b0, 1'b1, "R9 fill D");
    send(17, 1'b0, 1'b0, 1'b1, "R9 fill E");
    send(1,  1'b0, 1'b0, 1'b1, "R9 A evicted");
    send(13, 1'b0, 1'b0, 1'b0, "R9 D resident");
    send(5,  1'b0, 1'b0, 1'b0, "R9 B resident");
    send(9,  1'b0, 1'b0, 1'b1, "R9 C evicted");
    // R8: other sets untouched by set-1 traffic (set 0 empty since flush)
    send(0,  1'b0, 1'b0, 1'b1, "R8 set 0 miss");
    send(17, 1'b0, 1'b0, 1'b0, "R9 E resident");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule